// File: doc/BRIEF.md
# Checked-Write LED Brightness Register Bank

This block is the register storage that sits behind a two-wire serial slave front end in an LED driver. The front end has already decoded bus timing and the device address. It hands this block a stream of received bytes together with one-cycle start and stop indications. The block holds one 8-bit brightness value per output channel (sixteen by default) and a single mode register. It publishes all brightness values and the committed mode value on flat outputs for the PWM stage. When the front end asks for a byte to transmit, it supplies that byte from the register selected by the pointer.

The first byte after a start indication is a pointer. Its upper three bits choose how the register address moves after each access, and its lower five bits choose the register. Two movement codes are legal: one keeps the address fixed, and one steps through the brightness registers and wraps at the last channel. Every other code makes the access void.

The mode register is protected in three ways:
- It accepts a write only through a fixed-address pointer.
- It accepts only data bytes that carry the correct check-bit pattern.
- It applies an accepted value only when the stop indication closes the command.

A committed mode byte with its top bit set puts the whole block back into its default state on the next clock.

Top module: `led_regbank`

## Requirements
- R1: After reset, every brightness register is 00h, the mode output is 03h and the read data output is 00h.
- R2: The first byte after a start indication is taken as the pointer (bits [7:5] code, bits [4:0] address) and writes no register. A later read, with no new pointer, uses that pointer.
- R3: With code 000, every data byte goes to the same register, so a second data byte overwrites the first and the next register is not touched.
- R4: With code 001 and an address in 00h..0Fh, the address advances by one after each data byte or read byte, and wraps from 0Fh to 00h.
- R5: With a code other than 000 or 001, data bytes change no register and reads return 00h.
- R6: Addresses 10h..19h and 1Bh..1Fh hold no register. Writes to them are discarded and reads of them return 00h.
- R7: The mode register, at address 1Ah, takes data only when the pointer code is 000. With any other code, a write to 1Ah is discarded.
- R8: A mode data byte is accepted only if bit 6 is 0 and bit 1 is 1. Any other mode data byte is ignored, and the mode output keeps its value.
- R9: An accepted mode byte appears on the mode output only in the cycle after the stop indication, never earlier.
- R10: When the mode output has bit 7 set, on the next clock every brightness register becomes 00h, the mode output becomes 03h and the pointer clears.
- R11: A read request loads the register selected by the pointer onto the read data output one cycle later. Address 1Ah with code 000 returns the committed mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse: start or repeated start seen |
| frame_stop | input | 1 | One-cycle pulse: stop seen |
| byte_valid | input | 1 | One-cycle pulse: a received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| rd_req | input | 1 | One-cycle pulse: the front end needs a byte to transmit |
| rd_data_o | output | 8 | Registered read data |
| bright_o | output | 128 | Brightness registers, channel n at bits [8n+7:8n] |
| mode_o | output | 8 | Committed mode register |

## Verification
The stepping mode is tried with a seventeen-byte burst that starts at channel 5, so the last byte lands past the wrap. A full read-back with stepping then exposes any stride or wrap error as a wrong value on a known channel.

Three further patterns cover the void cases:
- Every prohibited code, combined with both a brightness address and the mode address, separates code decoding from address decoding.
- Every undefined address is tried with both legal codes.
- All 128 mode bytes with bit 7 clear are sent. The mode output is compared both before and after each stop, which shows the check-bit filter and the commit timing separately.

A final mode byte with bit 7 set shows the self-reset wiping brightness values that are known to be nonzero.

// File: rtl/led_regbank_pkg.sv
package led_regbank_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] INC_NONE = 3'b000;
  localparam logic [CODE_W-1:0] INC_STEP = 3'b001;

  localparam logic [ADDR_W-1:0] MODE_ADDR = 5'h1A;
  localparam logic [BYTE_W-1:0] MODE_DEFAULT = 8'h03;

  localparam int unsigned MODE_SELFRST_BIT = 7;
  localparam int unsigned MODE_CHK_ZERO_BIT = 6;
  localparam int unsigned MODE_CHK_ONE_BIT = 1;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
  } ptr_t;
endpackage

// File: rtl/led_ptr_ctrl.sv
module led_ptr_ctrl
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              rd_req,
  output logic              data_we,
  output logic              bright_hit,
  output logic              mode_hit,
  output logic [CH_W-1:0]   ch_idx
);
  ptr_t ptr_q;
  logic expect_ptr_q;
  logic code_ok;
  logic in_bank;
  logic advance;

  assign code_ok    = (ptr_q.code == INC_NONE) || (ptr_q.code == INC_STEP);
  assign in_bank    = ({27'd0, ptr_q.addr} < 32'(NUM_CH));
  assign bright_hit = code_ok && in_bank;
  assign mode_hit   = (ptr_q.code == INC_NONE) && (ptr_q.addr == MODE_ADDR);
  assign ch_idx     = ptr_q.addr[CH_W-1:0];
  assign data_we    = byte_valid && !expect_ptr_q;
  assign advance    = (data_we || rd_req) && (ptr_q.code == INC_STEP) && in_bank;

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr_q        <= '0;
      expect_ptr_q <= 1'b1;
    end else if (frame_start) begin
      expect_ptr_q <= 1'b1;
    end else if (byte_valid && expect_ptr_q) begin
      ptr_q        <= ptr_t'(byte_data);
      expect_ptr_q <= 1'b0;
    end else if (advance) begin
      if (ptr_q.addr == ADDR_W'(NUM_CH - 1)) ptr_q.addr <= '0;
      else ptr_q.addr <= ptr_q.addr + 1'b1;
    end
  end
endmodule

// File: rtl/led_bright_mem.sv
module led_bright_mem
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DW = 8,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we,
  input  logic [CH_W-1:0]   idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NUM_CH*DW-1:0] flat_o
);
  logic [DW-1:0] mem_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign flat_o[g*DW +: DW] = mem_q[g];
  end
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import led_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              frame_stop,
  output logic [BYTE_W-1:0] mode_o,
  output logic              self_rst
);
  logic [BYTE_W-1:0] mode_q;
  logic [BYTE_W-1:0] pend_q;
  logic              pend_v_q;
  logic              chk_ok;

  assign chk_ok   = !wdata[MODE_CHK_ZERO_BIT] && wdata[MODE_CHK_ONE_BIT];
  assign self_rst = mode_q[MODE_SELFRST_BIT];
  assign mode_o   = mode_q;

  always_ff @(posedge clk) begin
    if (rst || self_rst) begin
      mode_q   <= MODE_DEFAULT;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (frame_stop) begin
        if (pend_v_q) mode_q <= pend_q;
        pend_v_q <= 1'b0;
      end else if (we && chk_ok) begin
        pend_q   <= wdata;
        pend_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_regbank.sv
module led_regbank
  import led_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 frame_stop,
  input  logic                 byte_valid,
  input  logic [7:0]           byte_data,
  input  logic                 rd_req,
  output logic [7:0]           rd_data_o,
  output logic [NUM_CH*DW-1:0] bright_o,
  output logic [7:0]           mode_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic            self_rst;
  logic            clr;
  logic            data_we;
  logic            bright_hit;
  logic            mode_hit;
  logic [CH_W-1:0] ch_idx;
  logic [DW-1:0]   mem_rdata;
  logic [7:0]      rd_q;

  assign clr = rst || self_rst;

  led_ptr_ctrl #(.NUM_CH(NUM_CH)) u_ptr (
    .clk(clk), .clr(clr), .frame_start(frame_start),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
    .data_we(data_we), .bright_hit(bright_hit), .mode_hit(mode_hit),
    .ch_idx(ch_idx)
  );

  led_bright_mem #(.NUM_CH(NUM_CH), .DW(DW)) u_mem (
    .clk(clk), .clr(clr), .we(data_we && bright_hit), .idx(ch_idx),
    .wdata(byte_data[DW-1:0]), .rdata(mem_rdata), .flat_o(bright_o)
  );

  led_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .we(data_we && mode_hit), .wdata(byte_data),
    .frame_stop(frame_stop), .mode_o(mode_o), .self_rst(self_rst)
  );

  always_ff @(posedge clk) begin
    if (clr) rd_q <= '0;
    else if (rd_req) begin
      if (bright_hit) rd_q <= 8'(mem_rdata);
      else if (mode_hit) rd_q <= mode_o;
      else rd_q <= '0;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/led_regbank_chk.sv
module led_regbank_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_stop,
  input logic                 byte_valid,
  input logic [7:0]           rd_data_o,
  input logic [NUM_CH*DW-1:0] bright_o,
  input logic [7:0]           mode_o
);
  // R1
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mode_o == 8'h03 && bright_o == '0 && rd_data_o == 8'h00));

  // R9
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!frame_stop && !mode_o[7]) |=> $stable(mode_o));

  // R8
  p_mode_chk_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_o) |-> (!mode_o[6] && mode_o[1]));

  // R10
  p_self_reset_r10: assert property (@(posedge clk) disable iff (rst)
    mode_o[7] |=> (mode_o == 8'h03 && bright_o == '0 && rd_data_o == 8'h00));

  // R6
  p_bright_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !mode_o[7]) |=> $stable(bright_o));
endmodule

bind led_regbank led_regbank_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .frame_stop(frame_stop), .byte_valid(byte_valid),
  .rd_data_o(rd_data_o), .bright_o(bright_o), .mode_o(mode_o)
);

// File: tb/sim_led_regbank.sv
module sim_led_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, frame_stop = 1'b0, byte_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [7:0] rd_data_o;
  logic [NCH*8-1:0] bright_o;
  logic [7:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_b [NCH];
  logic [7:0] exp_mode;
  logic [7:0] rv;

  led_regbank u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_stop(frame_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
    .rd_data_o(rd_data_o), .bright_o(bright_o), .mode_o(mode_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NCH; i++) check(tag, bright_o[i*8 +: 8], exp_b[i]);
  endtask

  task automatic do_start();
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask
  task automatic do_stop();
    frame_stop = 1'b1; @(negedge clk); frame_stop = 1'b0;
  endtask
  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1; byte_data = b; @(negedge clk); byte_valid = 1'b0;
  endtask
  task automatic rd(output logic [7:0] v);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; v = rd_data_o;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) exp_b[i] = 8'h00;
    exp_mode = 8'h03;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_bank("R1 bright");
    check("R1 mode", mode_o, 8'h03);
    check("R1 rd", rd_data_o, 8'h00);

    // R4: stepping burst of 17 bytes from channel 5 wraps
    begin
      int a = 5;
      do_start(); send(8'h25);
      for (int i = 0; i < 17; i++) begin
        logic [7:0] v = 8'((i * 37 + 11) & 255);
        send(v); exp_b[a] = v; a = (a + 1) % NCH;
      end
      do_stop();
    end
    check_bank("R4 burst");

    // R11 + R4: stepping read-back with wrap
    do_start(); send(8'h20); do_start();
    for (int i = 0; i < NCH; i++) begin rd(rv); check("R11 read", rv, exp_b[i]); end
    rd(rv); check("R4 read wrap", rv, exp_b[0]);
    do_stop();

    // R3: fixed address overwrites
    do_start(); send(8'h03); send(8'hA1); send(8'hB2); do_stop();
    exp_b[3] = 8'hB2;
    check("R3 same reg", bright_o[3*8 +: 8], 8'hB2);
    check("R3 next untouched", bright_o[4*8 +: 8], exp_b[4]);

    // R2: pointer-only frame writes nothing, later read uses it
    do_start(); send(8'h27); do_stop();
    check_bank("R2 no write");
    do_start(); rd(rv); check("R2 ptr kept", rv, exp_b[7]); do_stop();

    // R5: prohibited codes
    for (int c = 2; c < 8; c++) begin
      do_start(); send({3'(c), 5'd0}); send(8'hEE); do_stop();
      check("R5 write void", bright_o[7:0], exp_b[0]);
      do_start(); send({3'(c), 5'd0}); rd(rv); do_stop();
      check("R5 read zero", rv, 8'h00);
      do_start(); send({3'(c), 5'h1A}); send(8'h12); do_stop();
      check("R5 mode void", mode_o, exp_mode);
    end

    // R6: undefined addresses
    for (int a = 16; a < 32; a++) begin
      if (a != 26) begin
        for (int c = 0; c < 2; c++) begin
          do_start(); send({3'(c), 5'(a)}); send(8'h5A); rd(rv); do_stop();
          check("R6 read zero", rv, 8'h00);
          check("R6 mode kept", mode_o, exp_mode);
        end
      end
    end
    check_bank("R6 bank kept");

    // R7: mode write needs code 000
    do_start(); send(8'h3A); send(8'h13); do_stop();
    check("R7 step code void", mode_o, exp_mode);

    // R8 / R9: all mode bytes with bit 7 clear
    for (int d = 0; d < 128; d++) begin
      do_start(); send(8'h1A); send(8'(d)); @(negedge clk);
      check("R9 before stop", mode_o, exp_mode);
      do_stop();
      if (((d >> 6) & 1) == 0 && ((d >> 1) & 1) == 1) exp_mode = 8'(d);
      check("R8 after stop", mode_o, exp_mode);
    end
    check("R8 final", mode_o, 8'h3F);
    check_bank("R7 bank kept");

    // R11: mode read-back
    do_start(); send(8'h1A); rd(rv); do_stop();
    check("R11 mode read", rv, 8'h3F);

    // R10: self reset
    do_start(); send(8'h1A); send(8'h83); do_stop();
    check("R9 commit", mode_o, 8'h83);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) exp_b[i] = 8'h00;
    exp_mode = 8'h03;
    check("R10 mode", mode_o, 8'h03);
    check_bank("R10 bank");
    do_start(); rd(rv); do_stop();
    check("R10 ptr cleared", rv, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule